// File: doc/BRIEF.md
# Deduplicating Miss Fetch Queue

This block sits between the tag-compare stage of a texture cache and the DRAM port. Each texel block address that missed in the cache is offered to the queue. If that block is already waiting, or is the block now being fetched, the offer is accepted and dropped. Otherwise the address is appended to a first-in, first-out list. As a result, one memory fetch serves every fragment that missed on the same block.

The queue sends fetches to memory one at a time, oldest first. When the memory side returns a fill for the outstanding fetch, the queue removes the head entry. In the same cycle it drives a single fill broadcast, carrying the block address and the eight-word block data, to both the waiting-list logic and the cache data array. Every requester whose duplicate miss was dropped is satisfied by that one broadcast.

Top module: `miss_fetch_queue`

## Requirements
- R1: Synchronous reset with `rst_n` low clears the queue. In the first cycle after reset, `miss_ready` is 1, `mem_req_valid` is 0 and `fill_valid` is 0.
- R2: When `miss_valid` is 1, the address matches no stored entry and the queue holds fewer than DEPTH (default 32) entries, the address is appended. Fetches are presented on `mem_req_addr` in the order their addresses were accepted.
- R3: An offered address equal to any stored entry gives `miss_ready` = 1 and adds nothing. This includes the entry whose fetch is outstanding.
- R4: In the cycle a fill pops the head, an offer of that same head address still counts as a duplicate. It is dropped and never fetched again.
- R5: When the queue holds DEPTH entries and the offered address matches none of them, `miss_ready` is 0 and the address is not stored. A pop in the same cycle does not lift this.
- R6: At most one fetch is outstanding. `mem_req_valid` stays 0 from the cycle after a request handshake (`mem_req_valid` and `mem_req_ready` both 1) up to and including the cycle of its fill.
- R7: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the next cycle keeps `mem_req_valid` at 1 with an unchanged `mem_req_addr`.
- R8: A `mem_fill_valid` pulse while a fetch is outstanding gives, in the same cycle, `fill_valid` = 1, `fill_addr` equal to the fetched address and `fill_data` equal to `mem_fill_data`. The head is removed at that clock edge.
- R9: A `mem_fill_valid` pulse when no fetch is outstanding is ignored. `fill_valid` stays 0 and the queue contents are unchanged.
- R10: Once a fill has removed an address, a later offer of that address is a new miss. It is appended and fetched again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | A missed block address is offered |
| miss_addr | input | ADDR_W | Missed block address |
| miss_ready | output | 1 | Offer taken, whether appended or merged |
| mem_req_valid | output | 1 | A fetch request is presented to memory |
| mem_req_addr | output | ADDR_W | Block address to fetch |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_fill_valid | input | 1 | Fill for the outstanding fetch |
| mem_fill_data | input | WORDS*WORD_W | Block data returned by memory |
| fill_valid | output | 1 | Fill broadcast to the waiting list and the cache |
| fill_addr | output | ADDR_W | Block address of the broadcast fill |
| fill_data | output | WORDS*WORD_W | Block data of the broadcast fill |

## Verification
A corrupted valid bit or pointer shows up at the ports within the next request or fill. A lost entry shows up as a missing request address. A stale entry shows up as a spurious `miss_ready` on an address that should be refused or appended, or as a request for an address that was already filled. The bench offers addresses from a small pool to force frequent merges. It compares every cycle's `miss_ready`, request address and fill broadcast against a queue model, so the divergence is caught in the cycle it first becomes visible. Directed cases fill the queue to capacity, merge into the in-flight head, and line up a duplicate with the pop of its own address.

// File: rtl/mfq_pkg.sv
// Package: shared defaults and types for the miss fetch queue.
// Assumes DEPTH >= 2 so that pointer widths are non-zero.
package mfq_pkg;
    localparam int DEF_ADDR_W = 26;
    localparam int DEF_DEPTH  = 32;
    localparam int DEF_WORDS  = 8;
    localparam int DEF_WORD_W = 32;

    // Issue sequencer state: idle (may request) or waiting for a fill
    typedef enum logic {
        ISS_IDLE = 1'b0,
        ISS_WAIT = 1'b1
    } iss_state_t;
endpackage

// File: rtl/mfq_cam.sv
// Module: mfq_cam
// Compares one key against every stored entry in parallel. An entry only
// matches when its valid bit is set. Assumes entries come from mfq_store.
module mfq_cam #(
    parameter int ADDR_W = mfq_pkg::DEF_ADDR_W,
    parameter int DEPTH  = mfq_pkg::DEF_DEPTH
) (
    input  logic [ADDR_W-1:0]             key,
    input  logic [DEPTH-1:0][ADDR_W-1:0]  entry_addr,
    input  logic [DEPTH-1:0]              entry_vld,
    output logic                          hit
);
    logic [DEPTH-1:0] hit_vec;

    // One comparator per slot
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign hit_vec[i] = entry_vld[i] && (entry_addr[i] == key);
    end

    // Any slot matching means the key is already queued
    assign hit = |hit_vec;
endmodule

// File: rtl/mfq_store.sv
// Module: mfq_store
// Circular slot store with per-slot valid bits, head/tail pointers and an
// occupancy count. The caller must never push when full or pop when empty.
module mfq_store #(
    parameter int ADDR_W = mfq_pkg::DEF_ADDR_W,
    parameter int DEPTH  = mfq_pkg::DEF_DEPTH
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic [ADDR_W-1:0]             push_addr,
    input  logic                          pop,
    output logic [DEPTH-1:0][ADDR_W-1:0]  entry_addr,
    output logic [DEPTH-1:0]              entry_vld,
    output logic [ADDR_W-1:0]             head_addr,
    output logic                          empty,
    output logic                          full
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(DEPTH);

    logic [PTR_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] cnt_q;

    // Advance a pointer with wrap at the last slot (any depth allowed)
    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == LAST_SLOT) ? '0 : p + 1'b1;
    endfunction

    // Per-slot storage: written at the tail on push, released at the head on pop
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry_vld[i]  <= 1'b0;
                entry_addr[i] <= '0;
            end else if (push && (tail_q == PTR_W'(i))) begin
                entry_vld[i]  <= 1'b1;
                entry_addr[i] <= push_addr;
            end else if (pop && (head_q == PTR_W'(i))) begin
                entry_vld[i]  <= 1'b0;
            end
        end
    end

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) tail_q <= ptr_inc(tail_q);
            if (pop)  head_q <= ptr_inc(head_q);
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Status and head view
    assign head_addr = entry_addr[head_q];
    assign empty     = (cnt_q == '0);
    assign full      = (cnt_q == CNT_FULL);
endmodule

// File: rtl/mfq_issue.sv
// Module: mfq_issue
// Keeps a single fetch outstanding. It presents the head while idle and the
// store is not empty, then waits for a fill. A fill while idle is ignored.
module mfq_issue (
    input  logic clk,
    input  logic rst_n,
    input  logic empty,
    input  logic mem_req_ready,
    input  logic mem_fill_valid,
    output logic mem_req_valid,
    output logic fill_pop
);
    import mfq_pkg::*;

    iss_state_t state_q, state_d;

    // Next-state and output decode
    always_comb begin
        state_d       = state_q;
        mem_req_valid = 1'b0;
        fill_pop      = 1'b0;
        case (state_q)
            ISS_IDLE: begin
                mem_req_valid = !empty;
                if (!empty && mem_req_ready) state_d = ISS_WAIT;
            end
            ISS_WAIT: begin
                if (mem_fill_valid) begin
                    fill_pop = 1'b1;
                    state_d  = ISS_IDLE;
                end
            end
            default: state_d = ISS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ISS_IDLE;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/miss_fetch_queue.sv
// Module: miss_fetch_queue (top)
// Deduplicating queue of missed block addresses. A new address is appended
// only if no stored entry (head included) matches. Fetches go out one at a
// time in order, and each fill is broadcast with the head address in the
// cycle it arrives. Assumes memory returns exactly one fill per fetch.
module miss_fetch_queue #(
    parameter int ADDR_W = mfq_pkg::DEF_ADDR_W,
    parameter int DEPTH  = mfq_pkg::DEF_DEPTH,
    parameter int WORDS  = mfq_pkg::DEF_WORDS,
    parameter int WORD_W = mfq_pkg::DEF_WORD_W,
    localparam int FILL_W = WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_addr,
    output logic              miss_ready,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_req_ready,
    input  logic              mem_fill_valid,
    input  logic [FILL_W-1:0] mem_fill_data,
    output logic              fill_valid,
    output logic [ADDR_W-1:0] fill_addr,
    output logic [FILL_W-1:0] fill_data
);
    logic [DEPTH-1:0][ADDR_W-1:0] entry_addr;
    logic [DEPTH-1:0]             entry_vld;
    logic [ADDR_W-1:0]            head_addr;
    logic                         empty, full, dup_hit, push, pop;

    mfq_cam #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_cam (
        .key        (miss_addr),
        .entry_addr (entry_addr),
        .entry_vld  (entry_vld),
        .hit        (dup_hit)
    );

    mfq_store #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_addr  (miss_addr),
        .pop        (pop),
        .entry_addr (entry_addr),
        .entry_vld  (entry_vld),
        .head_addr  (head_addr),
        .empty      (empty),
        .full       (full)
    );

    mfq_issue u_issue (
        .clk            (clk),
        .rst_n          (rst_n),
        .empty          (empty),
        .mem_req_ready  (mem_req_ready),
        .mem_fill_valid (mem_fill_valid),
        .mem_req_valid  (mem_req_valid),
        .fill_pop       (pop)
    );

    // Enqueue decision: merge on a match, refuse a new address when full
    always_comb begin
        miss_ready = dup_hit || !full;
        push       = miss_valid && !dup_hit && !full;
    end

    // Request and fill broadcast both carry the head address
    assign mem_req_addr = head_addr;
    assign fill_valid   = pop;
    assign fill_addr    = head_addr;
    assign fill_data    = mem_fill_data;
endmodule

// File: rtl/miss_fetch_queue_chk.sv
// Module: miss_fetch_queue_chk
// Protocol checker bound to miss_fetch_queue. It tracks the outstanding fetch
// independently from the request handshake and the fill broadcast.
module miss_fetch_queue_chk #(
    parameter int ADDR_W = mfq_pkg::DEF_ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_fill_valid,
    input logic              fill_valid,
    input logic [ADDR_W-1:0] fill_addr,
    input logic              miss_ready
);
    logic              pend_q;
    logic [ADDR_W-1:0] pend_addr_q;

    // Record the fetch handed to memory until its fill is broadcast
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            pend_addr_q <= '0;
        end else if (mem_req_valid && mem_req_ready) begin
            pend_q      <= 1'b1;
            pend_addr_q <= mem_req_addr;
        end else if (fill_valid) begin
            pend_q      <= 1'b0;
        end
    end

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (miss_ready && !mem_req_valid && !fill_valid));

    p_one_outstanding_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> !mem_req_valid);

    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    p_fill_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> (pend_q && fill_addr == pend_addr_q));

    p_fill_answers_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && mem_fill_valid) |-> fill_valid);

    p_stray_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_q && mem_fill_valid) |-> !fill_valid);
endmodule

bind miss_fetch_queue miss_fetch_queue_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .mem_req_valid  (mem_req_valid),
    .mem_req_ready  (mem_req_ready),
    .mem_req_addr   (mem_req_addr),
    .mem_fill_valid (mem_fill_valid),
    .fill_valid     (fill_valid),
    .fill_addr      (fill_addr),
    .miss_ready     (miss_ready)
);

// File: tb/miss_fetch_queue_bench.sv
// Bench: reference queue model, directed corners, then seeded random traffic.
module miss_fetch_queue_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 26;
    localparam int DEPTH = 32;
    localparam int FW    = 8 * 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          miss_valid = 1'b0;
    logic [AW-1:0] miss_addr = '0;
    logic          miss_ready;
    logic          mem_req_valid;
    logic [AW-1:0] mem_req_addr;
    logic          mem_req_ready = 1'b0;
    logic          mem_fill_valid = 1'b0;
    logic [FW-1:0] mem_fill_data = '0;
    logic          fill_valid;
    logic [AW-1:0] fill_addr;
    logic [FW-1:0] fill_data;

    int            n_cmp = 0;
    int            n_bad = 0;
    bit            finished = 0;
    logic [AW-1:0] mq[$];
    bit            outst = 0;
    logic [AW-1:0] watch_addr = '1;
    int            seen_watch = 0;

    miss_fetch_queue u_miss_fetch_queue (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_ready(miss_ready),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_ready(mem_req_ready),
        .mem_fill_valid(mem_fill_valid), .mem_fill_data(mem_fill_data),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [FW-1:0] act, input logic [FW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    function automatic bit model_has(input logic [AW-1:0] a);
        foreach (mq[i]) if (mq[i] == a) return 1;
        return 0;
    endfunction

    // One cycle: drive at the falling edge, compare, then advance the model
    task automatic step(input bit mv, input logic [AW-1:0] ma, input bit rr, input bit fv);
        bit dup, can_push, exp_rv, exp_fv;
        @(negedge clk);
        miss_valid = mv; miss_addr = ma; mem_req_ready = rr; mem_fill_valid = fv;
        for (int w = 0; w < 8; w++) mem_fill_data[w*32 +: 32] = $urandom;
        #1;
        dup      = model_has(ma);
        can_push = mv && !dup && (mq.size() < DEPTH);
        check(dup ? "R3" : ((mq.size() < DEPTH) ? "R2" : "R5"),
              FW'(miss_ready), FW'(dup || mq.size() < DEPTH));
        exp_rv = !outst && (mq.size() > 0);
        check("R6", FW'(mem_req_valid), FW'(exp_rv));
        if (exp_rv) check("R2", FW'(mem_req_addr), FW'(mq[0]));
        exp_fv = fv && outst;
        check(outst ? "R8" : "R9", FW'(fill_valid), FW'(exp_fv));
        if (exp_fv) begin
            check("R8", FW'(fill_addr), FW'(mq[0]));
            check("R8", fill_data, mem_fill_data);
        end
        if (exp_rv && rr) begin
            outst = 1;
            if (mq[0] == watch_addr) seen_watch++;
        end else if (exp_fv) begin
            void'(mq.pop_front());
            outst = 0;
        end
        if (can_push) mq.push_back(ma);
    endtask

    // Serve every queued fetch with no new misses
    task automatic drain();
        while (mq.size() > 0 || outst) step(1'b0, '0, 1'b1, outst);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1: state right after reset
        check("R1", FW'(miss_ready), FW'(1));
        check("R1", FW'(mem_req_valid), FW'(0));
        check("R1", FW'(fill_valid), FW'(0));

        // R5 / R7: fill to capacity while memory refuses the request
        for (int i = 0; i < DEPTH; i++) step(1'b1, AW'(100 + i), 1'b0, 1'b0);
        step(1'b1, AW'(200), 1'b0, 1'b0);           // R5 refused
        step(1'b1, AW'(105), 1'b0, 1'b1);           // R3 merge while full; R9 stray fill
        check("R5", FW'(mq.size()), FW'(DEPTH));

        // R3: merge into the in-flight head
        step(1'b0, '0, 1'b1, 1'b0);                 // handshake head 100
        step(1'b1, AW'(100), 1'b0, 1'b0);
        // R4: duplicate of the head in the same cycle as its fill
        watch_addr = AW'(100); seen_watch = 0;
        step(1'b1, AW'(100), 1'b0, 1'b1);
        drain();
        check("R4", FW'(seen_watch), FW'(0));

        // R10: an address filled earlier is fetched again
        step(1'b1, AW'(300), 1'b0, 1'b0);
        step(1'b0, '0, 1'b1, 1'b0);
        step(1'b0, '0, 1'b0, 1'b1);
        watch_addr = AW'(300); seen_watch = 0;
        step(1'b1, AW'(300), 1'b0, 1'b0);
        drain();
        check("R10", FW'(seen_watch), FW'(1));

        // Random traffic over a small address pool
        void'($urandom(32'h5eed_0042));
        for (int c = 0; c < 4000; c++)
            step(($urandom % 10) < 7, AW'($urandom % 48),
                 $urandom % 2, ($urandom % 4) == 0);
        drain();

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule